// File: doc/BRIEF.md
# Hub Downstream Port Power and Mode Strap Controller

This block drives the active-low power switches of a four-port hub's downstream ports and watches their active-low over-current flags. It works in one of two power arrangements: per-port (individual) switching, or a single shared (gang) switch and sense line that stands for every port. The arrangement is read once from a dual-use pin. That pin stays an input for a fixed number of millisecond ticks after reset. It is then turned into an output that reports whether the hub is running or suspended, and the polarity of that report depends on the arrangement that was read.

Over-current flags are synchronised and debounced against the millisecond tick. Once a condition is reported it stays latched and keeps the affected power switch off until firmware clears it with a per-port clear strobe. Power requests come in per port. In gang mode any request turns the shared switch on, and the switch is released only when no port requests power.

Top module: `hub_port_power`

## Requirements
- R1: While reset is low and in the first cycle after it, every pwrEnN bit is 1, every ocStat bit is 0 and pinOe is 0.
- R2: pinOe stays 0 (pin is an input, pinOut 0) until STRAP_MS millisecond ticks (default 50) have been counted after reset, then becomes 1 and stays 1 until the next reset.
- R3: gangMode equals the last value of modePin (after a two-flop synchroniser) seen before the window closes; modePin changes after the window have no effect on gangMode.
- R4: With gangMode 1, the pin output is 0 while suspend is 0 and 1 while suspend is 1.
- R5: With gangMode 0, the pin output is 1 while suspend is 0 and 0 while suspend is 1.
- R6: Every pwrEnN bit stays 1 for the whole strap window, whatever pwrReq holds.
- R7: In individual mode, pwrEnN[i] is 0 exactly when pwrReq[i] is 1 and ocStat[i] is 0, one cycle after the inputs.
- R8: In gang mode, pwrEnN[0] is 0 exactly when any pwrReq bit is 1 and ocStat[0] is 0; pwrEnN[3:1] stay 1.
- R9: An ocN bit must be held low for DEB_TICKS millisecond ticks (default 4) before the matching ocStat bit is set; a shorter low pulse leaves ocStat at 0.
- R10: A set ocStat[i] bit stays set after ocN[i] returns high, holds the matching enable off, and is cleared only by a pulse on ocClr[i].
- R11: In gang mode, over-current on ports 2 to 4 (ocN[3:1]) is ignored: ocStat[3:1] stay 0 and the shared enable is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset of the whole block |
| msTick | input | 1 | One-cycle pulse every millisecond |
| ocN | input | 4 | Active-low over-current flags, one per downstream port |
| pwrReq | input | 4 | Per-port power requests, active high |
| ocClr | input | 4 | Per-port strobe clearing a latched over-current |
| suspend | input | 1 | Hub is in the suspended state |
| modePin | input | 1 | Input value of the dual-use strap pin |
| pwrEnN | output | 4 | Active-low power switch enables |
| ocStat | output | 4 | Latched, debounced over-current status per port |
| gangMode | output | 1 | Sampled mode: 1 gang, 0 individual |
| pinOut | output | 1 | Value driven on the dual-use pin |
| pinOe | output | 1 | Output enable of the dual-use pin |

## Verification
The strap is tried with the pin flipped mid-window and restored before the end, which separates last-sample capture from first-sample capture, and with each mode read in turn to show both suspend polarities. Random request vectors in both modes separate per-port switching from the OR-combined shared switch. Over-current pulses one tick short of the threshold and exactly at it separate a correct debounce from an off-by-one, and over-current on a non-primary port in gang mode shows that those sense lines are masked.

// File: rtl/hub_pwr_pkg.sv
package hub_pwr_pkg;

  // Strobes from the strap control to the power datapath
  typedef struct packed {
    logic strapActive;  // strap window open: pin is input, enables forced off
    logic gangMode;     // 1: shared switch and sense on port 1
  } strapCtl_t;

endpackage

// File: rtl/hub_strap_ctrl.sv
module hub_strap_ctrl
  import hub_pwr_pkg::*;
#(
  parameter int STRAP_MS = 50
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      msTick,
  input  logic      modePin,
  input  logic      suspend,
  output strapCtl_t ctl,
  output logic      pinOut,
  output logic      pinOe
);

  localparam int STRAP_W = $clog2(STRAP_MS + 1);
  localparam logic [STRAP_W-1:0] LAST_TICK = STRAP_W'(STRAP_MS - 1);

  logic [1:0]         modeSync;
  logic [STRAP_W-1:0] winCnt;
  logic               strapActive;
  logic               gangReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSync    <= 2'b00;
      winCnt      <= '0;
      strapActive <= 1'b1;
      gangReg     <= 1'b0;
    end else begin
      modeSync <= {modeSync[0], modePin};
      if (strapActive) begin
        // keep overwriting so the last sample before closing wins
        gangReg <= modeSync[1];
        if (msTick) begin
          if (winCnt == LAST_TICK) begin
            strapActive <= 1'b0;
          end else begin
            winCnt <= winCnt + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    ctl.strapActive = strapActive;
    ctl.gangMode    = gangReg;
    pinOe           = ~strapActive;
    if (strapActive) begin
      pinOut = 1'b0;
    end else if (gangReg) begin
      pinOut = suspend;
    end else begin
      pinOut = ~suspend;
    end
  end

endmodule

// File: rtl/hub_oc_debounce.sv
module hub_oc_debounce #(
  parameter int DEB_TICKS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic ocActive,   // synchronised, active high
  input  logic monitorEn,  // port is watched in the current mode
  input  logic clr,
  output logic reported
);

  localparam int DEB_W = $clog2(DEB_TICKS + 1);
  localparam logic [DEB_W-1:0] LAST_CNT = DEB_W'(DEB_TICKS - 1);

  logic [DEB_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt  <= '0;
      reported <= 1'b0;
    end else if (clr || !monitorEn) begin
      holdCnt  <= '0;
      reported <= 1'b0;
    end else if (!ocActive) begin
      holdCnt <= '0;
    end else if (msTick && !reported) begin
      if (holdCnt == LAST_CNT) begin
        reported <= 1'b1;
        holdCnt  <= '0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/hub_pwr_datapath.sv
module hub_pwr_datapath
  import hub_pwr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DEB_TICKS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 msTick,
  input  strapCtl_t            ctl,
  input  logic [NUM_PORTS-1:0] ocN,
  input  logic [NUM_PORTS-1:0] pwrReq,
  input  logic [NUM_PORTS-1:0] ocClr,
  output logic [NUM_PORTS-1:0] pwrEnN,
  output logic [NUM_PORTS-1:0] ocStat
);

  logic [NUM_PORTS-1:0] ocMeta;
  logic [NUM_PORTS-1:0] ocSync;
  logic [NUM_PORTS-1:0] portLive;
  logic [NUM_PORTS-1:0] enNext;
  logic                 anyReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocMeta <= '1;
      ocSync <= '1;
    end else begin
      ocMeta <= ocN;
      ocSync <= ocMeta;
    end
  end

  assign anyReq = |pwrReq;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    if (p == 0) begin : gPrimary
      assign portLive[p] = 1'b1;
      always_comb begin
        if (ctl.strapActive) begin
          enNext[p] = 1'b0;
        end else if (ctl.gangMode) begin
          enNext[p] = anyReq & ~ocStat[p];
        end else begin
          enNext[p] = pwrReq[p] & ~ocStat[p];
        end
      end
    end else begin : gSecondary
      assign portLive[p] = ~ctl.gangMode;
      always_comb begin
        if (ctl.strapActive || ctl.gangMode) begin
          enNext[p] = 1'b0;
        end else begin
          enNext[p] = pwrReq[p] & ~ocStat[p];
        end
      end
    end

    hub_oc_debounce #(
      .DEB_TICKS(DEB_TICKS)
    ) u_deb (
      .clk      (clk),
      .rstN     (rstN),
      .msTick   (msTick),
      .ocActive (~ocSync[p]),
      .monitorEn(portLive[p]),
      .clr      (ocClr[p]),
      .reported (ocStat[p])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrEnN <= '1;
    end else begin
      pwrEnN <= ~enNext;
    end
  end

endmodule

// File: rtl/hub_port_power.sv
module hub_port_power
  import hub_pwr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int STRAP_MS  = 50,
  parameter int DEB_TICKS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 msTick,
  input  logic [NUM_PORTS-1:0] ocN,
  input  logic [NUM_PORTS-1:0] pwrReq,
  input  logic [NUM_PORTS-1:0] ocClr,
  input  logic                 suspend,
  input  logic                 modePin,
  output logic [NUM_PORTS-1:0] pwrEnN,
  output logic [NUM_PORTS-1:0] ocStat,
  output logic                 gangMode,
  output logic                 pinOut,
  output logic                 pinOe
);

  strapCtl_t ctl;

  hub_strap_ctrl #(
    .STRAP_MS(STRAP_MS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .msTick (msTick),
    .modePin(modePin),
    .suspend(suspend),
    .ctl    (ctl),
    .pinOut (pinOut),
    .pinOe  (pinOe)
  );

  hub_pwr_datapath #(
    .NUM_PORTS(NUM_PORTS),
    .DEB_TICKS(DEB_TICKS)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .msTick(msTick),
    .ctl   (ctl),
    .ocN   (ocN),
    .pwrReq(pwrReq),
    .ocClr (ocClr),
    .pwrEnN(pwrEnN),
    .ocStat(ocStat)
  );

  assign gangMode = ctl.gangMode;

endmodule

// File: rtl/hub_port_power_chk.sv
module hub_port_power_chk #(
  parameter int NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] pwrEnN,
  input logic [NUM_PORTS-1:0] ocStat,
  input logic                 gangMode,
  input logic                 pinOe
);

  // R6: no port is powered while the strap window is open
  assert_enables_off_in_strap_R6: assert property (
    @(posedge clk) disable iff (!rstN) !pinOe |-> (&pwrEnN)
  );

  // R2: once the pin becomes an output it stays one
  assert_output_mode_sticky_R2: assert property (
    @(posedge clk) disable iff (!rstN) pinOe |=> pinOe
  );

  // R3: the sampled mode is frozen after the window
  assert_mode_frozen_R3: assert property (
    @(posedge clk) disable iff (!rstN) pinOe |=> $stable(gangMode)
  );

  // R8: in gang mode only the first enable may be driven
  assert_gang_one_enable_R8: assert property (
    @(posedge clk) disable iff (!rstN)
      (gangMode && pinOe) |-> ((pwrEnN >> 1) == ((1 << (NUM_PORTS - 1)) - 1))
  );

  // R11: gang mode never reports the secondary sense lines
  assert_gang_masks_oc_R11: assert property (
    @(posedge clk) disable iff (!rstN) gangMode |=> ((ocStat >> 1) == '0)
  );

  // R10: a latched over-current keeps its enable off
  for (genvar p = 0; p < NUM_PORTS; p++) begin : gOc
    assert_oc_forces_off_R10: assert property (
      @(posedge clk) disable iff (!rstN) ocStat[p] |=> pwrEnN[p]
    );
  end

endmodule

bind hub_port_power hub_port_power_chk #(
  .NUM_PORTS(NUM_PORTS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pwrEnN  (pwrEnN),
  .ocStat  (ocStat),
  .gangMode(gangMode),
  .pinOe   (pinOe)
);

// File: tb/hub_port_power_tb.sv
module hub_port_power_tb;

  localparam int NP    = 4;
  localparam int STRAP = 50;
  localparam int DEB   = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          msTick = 1'b0;
  logic [NP-1:0] ocN = '1;
  logic [NP-1:0] pwrReq = '0;
  logic [NP-1:0] ocClr = '0;
  logic          suspend = 1'b0;
  logic          modePin = 1'b0;
  logic [NP-1:0] pwrEnN;
  logic [NP-1:0] ocStat;
  logic          gangMode;
  logic          pinOut;
  logic          pinOe;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  hub_port_power #(
    .NUM_PORTS(NP),
    .STRAP_MS (STRAP),
    .DEB_TICKS(DEB)
  ) u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .msTick  (msTick),
    .ocN     (ocN),
    .pwrReq  (pwrReq),
    .ocClr   (ocClr),
    .suspend (suspend),
    .modePin (modePin),
    .pwrEnN  (pwrEnN),
    .ocStat  (ocStat),
    .gangMode(gangMode),
    .pinOut  (pinOut),
    .pinOe   (pinOe)
  );

  function automatic logic [NP-1:0] expPwrN(input logic gang, input logic [NP-1:0] req,
                                            input logic [NP-1:0] latched);
    logic [NP-1:0] on;
    if (gang) begin
      on    = '0;
      on[0] = (|req) & ~latched[0];
    end else begin
      on = req & ~latched;
    end
    return ~on;
  endfunction

  function automatic logic expPin(input logic gang, input logic susp);
    return gang ? susp : ~susp;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) msTick = 1'b1;
    @(negedge clk) msTick = 1'b0;
  endtask

  task automatic doReset(input logic strapVal);
    @(negedge clk);
    rstN = 1'b0; modePin = strapVal; pwrReq = '0; ocN = '1; ocClr = '0;
    cyc(3);
    check("R1 reset enables", 32'(pwrEnN), 32'hF);
    check("R1 reset ocStat", 32'(ocStat), 32'h0);
    check("R1 reset pinOe", 32'(pinOe), 32'h0);
    rstN = 1'b1;
  endtask

  task automatic runWindow(input logic finalStrap);
    pwrReq = '1;
    for (int t = 0; t < STRAP - 1; t++) begin
      if (t == 10) modePin = ~finalStrap;
      if (t == 40) modePin = finalStrap;
      tick();
    end
    check("R2 still input before last tick", 32'(pinOe), 32'h0);
    check("R2 pin low during window", 32'(pinOut), 32'h0);
    check("R6 enables off in window", 32'(pwrEnN), 32'hF);
    tick();
    cyc(1);
    check("R2 output after window", 32'(pinOe), 32'h1);
    check("R3 sampled mode", 32'(gangMode), 32'(finalStrap));
    pwrReq = '0;
    cyc(2);
  endtask

  task automatic ocPulse(input int port, input int nTicks);
    ocN[port] = 1'b0;
    cyc(3);
    for (int t = 0; t < nTicks; t++) tick();
    cyc(2);
  endtask

  initial begin
    logic [NP-1:0] r;
    void'($urandom(32'd20240611));

    // ---------------- individual mode ----------------
    doReset(1'b0);
    runWindow(1'b0);
    modePin = 1'b1;
    cyc(5);
    check("R3 mode ignores pin after window", 32'(gangMode), 32'h0);
    suspend = 1'b0; cyc(1);
    check("R5 indiv normal", 32'(pinOut), 32'(expPin(1'b0, 1'b0)));
    suspend = 1'b1; cyc(1);
    check("R5 indiv suspend", 32'(pinOut), 32'(expPin(1'b0, 1'b1)));
    suspend = 1'b0;

    for (int i = 0; i < 20; i++) begin
      r = NP'($urandom);
      pwrReq = r;
      cyc(2);
      check("R7 indiv enables", 32'(pwrEnN), 32'(expPwrN(1'b0, r, '0)));
    end

    pwrReq = '1;
    ocPulse(2, DEB - 1);
    ocN[2] = 1'b1;
    cyc(3);
    check("R9 short pulse not reported", 32'(ocStat), 32'h0);
    ocPulse(2, DEB);
    check("R9 held pulse reported", 32'(ocStat), 32'h4);
    check("R10 oc forces port off", 32'(pwrEnN), 32'(expPwrN(1'b0, 4'hF, 4'h4)));
    ocN[2] = 1'b1;
    cyc(5);
    check("R10 stays latched", 32'(ocStat), 32'h4);
    ocClr[2] = 1'b1; cyc(1); ocClr[2] = 1'b0;
    cyc(2);
    check("R10 cleared", 32'(ocStat), 32'h0);
    check("R10 power restored", 32'(pwrEnN), 32'h0);

    // ---------------- gang mode ----------------
    doReset(1'b1);
    runWindow(1'b1);
    suspend = 1'b0; cyc(1);
    check("R4 gang normal", 32'(pinOut), 32'(expPin(1'b1, 1'b0)));
    suspend = 1'b1; cyc(1);
    check("R4 gang suspend", 32'(pinOut), 32'(expPin(1'b1, 1'b1)));
    suspend = 1'b0;

    for (int i = 0; i < 20; i++) begin
      r = (i == 0) ? '0 : (i == 1) ? NP'(4'h8) : NP'($urandom);
      pwrReq = r;
      cyc(2);
      check("R8 gang enables", 32'(pwrEnN), 32'(expPwrN(1'b1, r, '0)));
    end

    pwrReq = 4'h2;
    ocPulse(1, DEB + 2);
    check("R11 secondary oc ignored", 32'(ocStat), 32'h0);
    check("R11 shared enable unaffected", 32'(pwrEnN), 32'(expPwrN(1'b1, 4'h2, '0)));
    ocN[1] = 1'b1;
    ocPulse(0, DEB);
    check("R10 gang primary oc", 32'(ocStat), 32'h1);
    check("R10 gang shared off", 32'(pwrEnN), 32'hF);
    ocN[0] = 1'b1;
    ocClr[0] = 1'b1; cyc(1); ocClr[0] = 1'b0;
    cyc(2);
    check("R10 gang cleared", 32'(pwrEnN), 32'(expPwrN(1'b1, 4'h2, '0)));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule